// File: doc/BRIEF.md
# Memory Line Sweep Initializer and Tester

This engine walks a contiguous region of memory one 64-byte line at a time, starting at line zero and ending at a programmed last line index. The last index is the region's byte size divided by 64, minus one. It has two run modes. A clear run writes all-zero lines once across the region, so that the check bits of an error-correcting memory start out consistent. A test run makes four passes over the region: it writes a fixed pattern, reads it back and compares, writes the bitwise inverse, then reads and compares again.

Mismatches are recorded per byte lane of the line, in a sticky error word. Each bit is the OR over every compared line. After each read pass the engine looks at that word. If any bit is set, the remaining passes are skipped. Software starts a run with a one-cycle start pulse and polls the busy output until it drops. It clears old errors with a separate clear pulse before the next run.

The engine reaches memory through a request port with a valid/ready handshake and a response port that carries read data. Only one request is outstanding at a time.

Top module: `sweep_engine`

## Requirements
- R1: Every request carries a line index. Within each pass the indices run 0, 1, ... up to the last line index captured at start, one request per line.
- R2: Mode code 2'b01 (clear) makes one pass of write requests with all-zero data and no read requests, then ends.
- R3: Mode code 2'b10 (test) runs four passes in this order: write, read, write, read. Write data in the first pass is made of 16-bit words, with 16'h5AA5 at even word positions and 16'hA55A at odd word positions. Word 0 is bits [15:0]. The second write pass uses the bitwise inverse of that data.
- R4: In a read pass, each response is compared with the data of the preceding write pass. A mismatch anywhere in byte lane i (bits 8i+7..8i) sets bit i of err_lanes. The bits are sticky and are ORed across all lines.
- R5: After a read pass has finished all its lines, a nonzero err_lanes ends the run and skips the remaining passes. Bits still set from an earlier run also count.
- R6: busy rises the cycle after an accepted start and falls once the final pass completes. A start pulse while busy is ignored.
- R7: A pulse on err_clr while the engine is idle resets err_lanes to zero.
- R8: A start with mode 2'b00 or 2'b11 issues no request, leaves busy low, and sets err_lanes to all ones.
- R9: At most one request is outstanding. After a read is accepted, no new request is made until its response arrives. While req_valid is high and req_ready is low, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request |
| mode | input | 2 | Run mode: 01 clear, 10 test |
| err_clr | input | 1 | Clears err_lanes when idle |
| last_line | input | AW | Index of the final line of the region |
| busy | output | 1 | High while a run is in progress |
| err_lanes | output | LANES | Sticky per-byte-lane mismatch bits |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | AW | Line index of the request |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_rdata | input | DATA_W | Read response data |

## Verification
The hardest situations to reach are the early abort and the OR across lines. Both need the read data to differ from what was written, and that does not happen with a healthy memory. The bench memory model therefore corrupts chosen byte lanes on selected reads, counted by read index. One fault in the first read pass must stop the run after exactly one write pass and one read pass. Two faults on different lines must show up as the union of their lanes. A fault placed only in the final read pass must leave all four passes complete. A further directed case leaves old error bits uncleared, so that a clean memory still ends the run early.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } sweep_state_e;

    localparam logic [1:0] MODE_CLEAR = 2'b01;
    localparam logic [1:0] MODE_TEST  = 2'b10;

    localparam logic [15:0] WORD_EVEN = 16'h5AA5;
    localparam logic [15:0] WORD_ODD  = 16'hA55A;

endpackage

// File: rtl/sweep_pattern.sv
module sweep_pattern #(
    parameter int DATA_W = 512
) (
    input  logic              invert,
    output logic [DATA_W-1:0] data
);
    import sweep_pkg::*;

    localparam int WORDS = DATA_W / 16;

    logic [DATA_W-1:0] base;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            if (w % 2 == 0) begin : g_even
                assign base[16*w +: 16] = WORD_EVEN;
            end else begin : g_odd
                assign base[16*w +: 16] = WORD_ODD;
            end
        end
    endgenerate

    assign data = invert ? ~base : base;

endmodule

// File: rtl/sweep_lane_cmp.sv
module sweep_lane_cmp #(
    parameter int DATA_W = 512
) (
    input  logic [DATA_W-1:0]   got,
    input  logic [DATA_W-1:0]   want,
    output logic [DATA_W/8-1:0] miss
);
    localparam int LANES = DATA_W / 8;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign miss[i] = (got[8*i +: 8] != want[8*i +: 8]);
        end
    endgenerate

endmodule

// File: rtl/sweep_engine.sv
module sweep_engine #(
    parameter int AW     = 26,
    parameter int DATA_W = 512,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              err_clr,
    input  logic [AW-1:0]     last_line,
    output logic              busy,
    output logic [LANES-1:0]  err_lanes,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [AW-1:0]     req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata
);
    import sweep_pkg::*;

    localparam int PASS_W     = 2;
    localparam int LAST_PASS  = 3;

    typedef struct packed {
        sweep_state_e      st;
        logic [PASS_W-1:0] pass;
        logic [AW-1:0]     line;
        logic [AW-1:0]     last;
        logic [1:0]        mode;
        logic [LANES-1:0]  err;
    } eng_t;

    eng_t q, d;

    logic [DATA_W-1:0] pat_data;
    logic [LANES-1:0]  lane_miss;
    logic              is_read;
    logic              mode_ok;

    // passes 0 and 1 use the plain pattern, 2 and 3 the inverse
    sweep_pattern #(.DATA_W(DATA_W)) i_pattern (
        .invert (q.pass[1]),
        .data   (pat_data)
    );

    sweep_lane_cmp #(.DATA_W(DATA_W)) i_cmp (
        .got  (rsp_rdata),
        .want (pat_data),
        .miss (lane_miss)
    );

    assign is_read = (q.mode == MODE_TEST) && q.pass[0];
    assign mode_ok = (mode == MODE_CLEAR) || (mode == MODE_TEST);

    always_comb begin
        logic [LANES-1:0] err_n;
        logic             step;
        d     = q;
        err_n = q.err;
        step  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (err_clr) d.err = '0;
                if (start) begin
                    if (mode_ok) begin
                        d.st   = ST_REQ;
                        d.pass = '0;
                        d.line = '0;
                        d.last = last_line;
                        d.mode = mode;
                    end else begin
                        d.err = '1;
                    end
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    if (is_read) d.st = ST_WAIT;
                    else         step = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    err_n = q.err | lane_miss;
                    d.err = err_n;
                    step  = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (step) begin
            if (q.line != q.last) begin
                d.line = q.line + 1'b1;
                d.st   = ST_REQ;
            end else if (q.mode == MODE_CLEAR || q.pass == PASS_W'(LAST_PASS) ||
                         (is_read && err_n != '0)) begin
                d.st = ST_IDLE;
            end else begin
                d.pass = q.pass + 1'b1;
                d.line = '0;
                d.st   = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, pass: '0, line: '0, last: '0, mode: '0, err: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign err_lanes = q.err;
    assign req_valid = (q.st == ST_REQ);
    assign req_write = !is_read;
    assign req_addr  = q.line;
    assign req_wdata = (q.mode == MODE_CLEAR) ? '0 : pat_data;

    // R9: request fields hold while stalled
    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

    // R9: no new request while a read response is pending
    p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !req_valid);

    // R1: addresses never pass the captured last line
    p_addr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr <= q.last));

    // R2: a clear run issues writes only
    p_clear_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && q.mode == MODE_CLEAR) |-> req_write);

    // R4: error bits are never dropped during a run
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((err_lanes & $past(err_lanes)) == $past(err_lanes)));

    // R6: a run begins only from a start pulse
    p_busy_from_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: an unknown mode keeps the engine idle and flags all lanes
    p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !mode_ok) |=> (!busy && err_lanes == '1));

endmodule

// File: tb/test_sweep_engine.sv
module test_sweep_engine;

    localparam int AW     = 26;
    localparam int DW     = 512;
    localparam int LN     = DW / 8;
    localparam int DEPTH  = 16;

    typedef struct packed {
        logic [1:0]    mode;
        int            last;
        int            f0;
        logic [LN-1:0] m0;
        int            f1;
        logic [LN-1:0] m1;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01,  7, -1, 64'h0, -1, 64'h0},
        '{2'b10,  7, -1, 64'h0, -1, 64'h0},
        '{2'b10,  0, -1, 64'h0, -1, 64'h0},
        '{2'b10,  5,  2, 64'h1, -1, 64'h0},
        '{2'b10,  5,  7, 64'h8000_0000_0000_0000, -1, 64'h0},
        '{2'b10,  3,  1, 64'h3,  3, 64'hF0},
        '{2'b10, 15, 31, 64'h100, -1, 64'h0},
        '{2'b01, 15, -1, 64'h0, -1, 64'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          err_clr = 1'b0;
    logic [AW-1:0] last_line = '0;
    logic          busy;
    logic [LN-1:0] err_lanes;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_rdata = '0;

    always #4 clk = ~clk;

    sweep_engine #(.AW(AW), .DATA_W(DW)) i_sweep_engine (
        .clk, .rst_n, .start, .mode, .err_clr, .last_line, .busy, .err_lanes,
        .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
        .rsp_valid, .rsp_rdata
    );

    int tests = 0;
    int fails = 0;

    // memory model state
    logic [DW-1:0] mem [DEPTH];
    int            wcnt, rcnt, seq_bad, acc_idx, cyc;
    int            cur_last, fi0, fi1;
    logic [1:0]    cur_mode;
    logic [LN-1:0] fm0, fm1;

    function automatic logic [DW-1:0] pat(input logic inv);
        logic [DW-1:0] v;
        for (int w = 0; w < DW / 16; w++)
            v[16*w +: 16] = (w % 2 == 0) ? 16'h5AA5 : 16'hA55A;
        return inv ? ~v : v;
    endfunction

    function automatic logic [DW-1:0] expand(input logic [LN-1:0] m);
        logic [DW-1:0] v;
        for (int i = 0; i < LN; i++) v[8*i +: 8] = {8{m[i]}};
        return v;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        req_ready <= (cyc % 4 != 2);
        rsp_valid <= 1'b0;
        if (req_valid && req_ready) begin
            int n, p, l;
            n = cur_last + 1;
            p = acc_idx / n;
            l = acc_idx % n;
            acc_idx <= acc_idx + 1;
            if (req_addr != AW'(l) || req_addr >= DEPTH) seq_bad <= seq_bad + 1;
            if (req_write) begin
                if (cur_mode == 2'b01) begin
                    if (req_wdata != '0 || p != 0) seq_bad <= seq_bad + 1;
                end else if (p[0] || req_wdata != pat(p[1])) begin
                    seq_bad <= seq_bad + 1;
                end
                mem[req_addr[3:0]] <= req_wdata;
                wcnt <= wcnt + 1;
            end else begin
                logic [DW-1:0] r;
                r = mem[req_addr[3:0]];
                if (rcnt == fi0) r = r ^ expand(fm0);
                if (rcnt == fi1) r = r ^ expand(fm1);
                if (cur_mode != 2'b10 || !p[0]) seq_bad <= seq_bad + 1;
                rsp_valid <= 1'b1;
                rsp_rdata <= r;
                rcnt <= rcnt + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [LN-1:0] act,
                       input logic [LN-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_err();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic run(input logic [1:0] md, input int last, input int f0,
                       input logic [LN-1:0] m0, input int f1, input logic [LN-1:0] m1,
                       input bit poke_busy);
        int t;
        @(negedge clk);
        wcnt = 0; rcnt = 0; seq_bad = 0; acc_idx = 0;
        cur_mode = md; cur_last = last; fi0 = f0; fi1 = f1; fm0 = m0; fm1 = m1;
        start = 1'b1; mode = md; last_line = AW'(last);
        @(negedge clk) start = 1'b0;
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
            if (poke_busy && t == 5) begin
                start = 1'b1; mode = 2'b01; last_line = '0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (t >= 5000) begin
            fails++; tests++;
            $display("FAIL R6 run watchdog: busy still 1 expected 0");
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
        cyc = 0; wcnt = 0; rcnt = 0; seq_bad = 0; acc_idx = 0;
        cur_last = 0; cur_mode = 2'b00; fi0 = -1; fi1 = -1; fm0 = '0; fm1 = '0;
        repeat (3) @(negedge clk);
        // reset state
        chk("R6", "reset busy", LN'(busy), '0);
        chk("R4", "reset err", err_lanes, '0);
        chk("R9", "reset req_valid", LN'(req_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            int n, ew, er, bad;
            logic [LN-1:0] ee;
            bit abort;
            vec_t x;
            x = VECS[v];
            clear_err();
            run(x.mode, x.last, x.f0, x.m0, x.f1, x.m1, 1'b0);
            n = x.last + 1;
            abort = (x.mode == 2'b10) && ((x.f0 >= 0 && x.f0 < n) || (x.f1 >= 0 && x.f1 < n));
            if (x.mode == 2'b01) begin ew = n; er = 0; end
            else if (abort)     begin ew = n; er = n; end
            else                begin ew = 2*n; er = 2*n; end
            ee = '0;
            if (x.f0 >= 0 && x.f0 < er) ee |= x.m0;
            if (x.f1 >= 0 && x.f1 < er) ee |= x.m1;
            chk(x.mode == 2'b01 ? "R2" : "R3", "write count", LN'(wcnt), LN'(ew));
            chk(x.mode == 2'b01 ? "R2" : "R5", "read count", LN'(rcnt), LN'(er));
            chk("R4", "lane errors", err_lanes, ee);
            chk("R1", "address/data order", LN'(seq_bad), '0);
            chk("R6", "busy after run", LN'(busy), '0);
            bad = 0;
            for (int l = 0; l < n; l++) begin
                logic [DW-1:0] want;
                want = (x.mode == 2'b01) ? '0 : pat(!abort);
                if (mem[l] != want) bad++;
            end
            chk(x.mode == 2'b01 ? "R2" : "R3", "memory image", LN'(bad), '0);
        end

        // R5: stale error bits without a clear end a clean test run early
        clear_err();
        run(2'b10, 1, 0, 64'h4, -1, 64'h0, 1'b0);
        run(2'b10, 1, -1, 64'h0, -1, 64'h0, 1'b0);
        chk("R5", "stale error read count", LN'(rcnt), LN'(2));
        chk("R5", "stale error write count", LN'(wcnt), LN'(2));
        chk("R7", "err kept without clear", err_lanes, 64'h4);
        clear_err();
        chk("R7", "err after clear", err_lanes, '0);

        // R8: unknown modes
        for (int k = 0; k < 2; k++) begin
            clear_err();
            run(k == 0 ? 2'b11 : 2'b00, 3, -1, 64'h0, -1, 64'h0, 1'b0);
            chk("R8", "bad mode err", err_lanes, '1);
            chk("R8", "bad mode requests", LN'(wcnt + rcnt), '0);
            chk("R8", "bad mode busy", LN'(busy), '0);
        end

        // R6: start while busy is ignored
        clear_err();
        run(2'b10, 7, -1, 64'h0, -1, 64'h0, 1'b1);
        chk("R6", "start while busy writes", LN'(wcnt), LN'(16));
        chk("R6", "start while busy reads", LN'(rcnt), LN'(16));
        chk("R6", "start while busy order", LN'(seq_bad), '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R6 global watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule